// File: doc/BRIEF.md
# Double-Buffered Word-Bus DAC Input Register

This block is the digital front end of a 14-bit converter that is written from a 14-bit parallel bus. Inside it are two input registers: an upper one that holds code bits 13..8 and a lower one that holds bits 7..0. It also holds the DAC register, whose value is the block's output and drives the converter's switches. Four active-low strobes control it: an upper select, a lower select, a shared write and a load-DAC. Their combination picks the action. The block can load one input register, load both, move the input registers into the DAC register, or pass the bus straight through to every register at once. That last mode lets software put zero or full scale on the output with a single write.

All strobes are sampled on the rising clock edge, and every register updates on that edge. There is no valid/ready handshake and no back-pressure: every sampled strobe combination is acted on in that cycle, and the bus owner never waits. The load-DAC line may be wired to several instances, so that all of them move their staged codes into their DAC registers on the same edge.

The load-DAC strobe has a hold rule. If it was low during the last write-low cycle, it must stay low for `LD_MIN` sampled cycles from the cycle in which write rises. A breach sets a sticky error flag, and only the clear input resets that flag.

Top module: `dacfe_top`

## Requirements
- R1: With write low, upper select low, lower select high and load high, the upper input register takes din[13:8]. No other register changes.
- R2: With write low, lower select low, upper select high and load high, the lower input register takes din[7:0]. No other register changes.
- R3: With write low, both selects low and load high, both input registers load from din in the same cycle, and the DAC output does not change.
- R4: With write low, load low and both selects high, dac_out takes {upper, lower} on the next clock edge.
- R5: With write, load and both selects all low, dac_out and both input registers take din on the next clock edge.
- R6: While write is high, no register changes, whatever the selects, load and din are. With write low, both selects high and load high, no register changes either.
- R7: With write low, load low and exactly one select low, the selected byte loads from din. In the same edge dac_out takes the merged word: the new byte together with the other register's held value.
- R8: The hold window applies when load was low in the last write-low cycle. If load is sampled high in the cycle where write rises, or in any of the next LD_MIN-1 cycles, hold_err is 1 after the following edge.
- R9: hold_err stays 1 until a cycle with err_clr high clears it. A new violation in the same cycle as a clear wins, and the flag stays 1.
- R10: Two instances that share write and load-DAC update their DAC registers on the same clock edge.
- R11: A synchronous reset (rst high at an edge) clears both input registers, dac_out and hold_err to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel_hi_n | input | 1 | Upper input register select, active low |
| sel_lo_n | input | 1 | Lower input register select, active low |
| wr_n | input | 1 | Shared write strobe, active low |
| ld_n | input | 1 | Load-DAC strobe, active low |
| err_clr | input | 1 | Clears the hold-error flag |
| din | input | DW (14) | Data bus |
| dac_out | output | DW (14) | DAC register value |
| hold_err | output | 1 | Sticky load-DAC hold violation flag |

## Verification
Two functions can fall in the same edge. The first pair is a byte load with a transfer (R7, R5): the transfer must see the byte that arrives in that cycle, not the one held before it. The second pair is a new hold violation with an error clear (R9). The bench provokes both with directed sequences, and the random phase covers them again by driving random strobe combinations with clear asserted now and then. A cycle model computed from the requirements judges every cycle.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  // Per-cycle register enables decoded from the strobes.
  typedef struct packed {
    logic ld_hi;
    logic ld_lo;
    logic xfer;
  } dacfe_en_t;
endpackage

// File: rtl/dacfe_decode.sv
module dacfe_decode
  import dacfe_pkg::*;
(
  input  logic      sel_hi_n,
  input  logic      sel_lo_n,
  input  logic      wr_n,
  input  logic      ld_n,
  output dacfe_en_t en
);
  // Write gates every action; selects and load combine freely,
  // which yields the single, dual, transfer and transparent cases.
  always_comb begin
    en.ld_hi = ~wr_n & ~sel_hi_n;
    en.ld_lo = ~wr_n & ~sel_lo_n;
    en.xfer  = ~wr_n & ~ld_n;
  end
endmodule

// File: rtl/dacfe_regs.sv
module dacfe_regs
  import dacfe_pkg::*;
#(
  parameter int DW = 14,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  dacfe_en_t     en,
  input  logic [DW-1:0] din,
  output logic [DW-LW-1:0] hi_q,
  output logic [LW-1:0] lo_q,
  output logic [DW-1:0] dac_q
);
  localparam int HW = DW - LW;

  logic [HW-1:0] hi_nx;
  logic [LW-1:0] lo_nx;

  // Staged bytes as they will be after this edge; the transfer path
  // reads these so a byte written in the same cycle reaches the DAC.
  always_comb begin
    hi_nx = en.ld_hi ? din[DW-1:LW] : hi_q;
    lo_nx = en.ld_lo ? din[LW-1:0]  : lo_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      lo_q  <= '0;
      dac_q <= '0;
    end else begin
      hi_q <= hi_nx;
      lo_q <= lo_nx;
      if (en.xfer) dac_q <= {hi_nx, lo_nx};
    end
  end
endmodule

// File: rtl/dacfe_holdmon.sv
module dacfe_holdmon #(
  parameter int LD_MIN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_n,
  input  logic ld_n,
  input  logic err_clr,
  output logic hold_err
);
  localparam int CW = (LD_MIN > 1) ? $clog2(LD_MIN) : 1;

  logic          wr_q, ld_q;
  logic [CW-1:0] rem;
  logic          rise_held, viol;

  // Write released while load was held during the write.
  assign rise_held = wr_n & ~wr_q & ~ld_q;
  assign viol      = ld_n & (rise_held | (rem != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= 1'b1;
      ld_q <= 1'b1;
    end else begin
      wr_q <= wr_n;
      ld_q <= ld_n;
    end
  end

  generate
    if (LD_MIN > 1) begin : g_window
      always_ff @(posedge clk) begin
        if (rst)                     rem <= '0;
        else if (rise_held && !ld_n) rem <= CW'(LD_MIN - 1);
        else if (rem != '0)          rem <= ld_n ? '0 : rem - 1'b1;
      end
    end else begin : g_nowindow
      assign rem = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          hold_err <= 1'b0;
    else if (viol)    hold_err <= 1'b1;
    else if (err_clr) hold_err <= 1'b0;
  end
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
  import dacfe_pkg::*;
#(
  parameter int DW     = 14,
  parameter int LW     = 8,
  parameter int LD_MIN = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_hi_n,
  input  logic          sel_lo_n,
  input  logic          wr_n,
  input  logic          ld_n,
  input  logic          err_clr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dac_out,
  output logic          hold_err
);
  localparam int HW = DW - LW;

  dacfe_en_t     en;
  logic [HW-1:0] hi_q;
  logic [LW-1:0] lo_q;

  dacfe_decode u_dec (
    .sel_hi_n (sel_hi_n),
    .sel_lo_n (sel_lo_n),
    .wr_n     (wr_n),
    .ld_n     (ld_n),
    .en       (en)
  );

  dacfe_regs #(.DW(DW), .LW(LW)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .din   (din),
    .hi_q  (hi_q),
    .lo_q  (lo_q),
    .dac_q (dac_out)
  );

  dacfe_holdmon #(.LD_MIN(LD_MIN)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .wr_n     (wr_n),
    .ld_n     (ld_n),
    .err_clr  (err_clr),
    .hold_err (hold_err)
  );
endmodule

// File: rtl/dacfe_sva.sv
module dacfe_sva #(
  parameter int DW     = 14,
  parameter int LW     = 8,
  parameter int LD_MIN = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             sel_hi_n,
  input logic             sel_lo_n,
  input logic             wr_n,
  input logic             ld_n,
  input logic             err_clr,
  input logic [DW-1:0]    din,
  input logic [DW-1:0]    dac_out,
  input logic             hold_err,
  input logic [DW-LW-1:0] hi_q,
  input logic [LW-1:0]    lo_q
);
  // R11
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (dac_out == '0 && !hold_err && hi_q == '0 && lo_q == '0));

  // R6
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    wr_n |=> ($stable(dac_out) && $stable(hi_q) && $stable(lo_q)));

  // R4
  xfer_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !ld_n && sel_hi_n && sel_lo_n) |=> dac_out == $past({hi_q, lo_q}));

  // R5
  transp_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !ld_n && !sel_hi_n && !sel_lo_n) |=> dac_out == $past(din));

  // R1
  upper_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !sel_hi_n) |=> hi_q == $past(din[DW-1:LW]));

  // R2
  lower_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !sel_lo_n) |=> lo_q == $past(din[LW-1:0]));

  // R8
  hold_viol_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && wr_n && !$past(wr_n) && !$past(ld_n) && ld_n) |=> hold_err);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_err && !err_clr) |=> hold_err);
endmodule

bind dacfe_top dacfe_sva #(.DW(DW), .LW(LW), .LD_MIN(LD_MIN)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .sel_hi_n (sel_hi_n),
  .sel_lo_n (sel_lo_n),
  .wr_n     (wr_n),
  .ld_n     (ld_n),
  .err_clr  (err_clr),
  .din      (din),
  .dac_out  (dac_out),
  .hold_err (hold_err),
  .hi_q     (hi_q),
  .lo_q     (lo_q)
);

// File: tb/dacfe_top_tb_top.sv
`timescale 1ns/1ps
module dacfe_top_tb_top;
  localparam int DW = 14, LW = 8, LDM = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, wr_n = 1'b1, ld_n = 1'b1, clr = 1'b0;
  logic sh_n = 1'b1, sl_n = 1'b1, bsh_n = 1'b1, bsl_n = 1'b1;
  logic [DW-1:0] din = '0, bdin = '0;
  logic [DW-1:0] dac_a, dac_b;
  logic err_a, err_b;

  dacfe_top #(.DW(DW), .LW(LW), .LD_MIN(LDM)) dut_i (
    .clk(clk), .rst(rst), .sel_hi_n(sh_n), .sel_lo_n(sl_n), .wr_n(wr_n),
    .ld_n(ld_n), .err_clr(clr), .din(din), .dac_out(dac_a), .hold_err(err_a));

  dacfe_top #(.DW(DW), .LW(LW), .LD_MIN(LDM)) dut_b (
    .clk(clk), .rst(rst), .sel_hi_n(bsh_n), .sel_lo_n(bsl_n), .wr_n(wr_n),
    .ld_n(ld_n), .err_clr(clr), .din(bdin), .dac_out(dac_b), .hold_err(err_b));

  int total = 0, bad = 0;
  bit done = 0;

  // Expected state, built from the requirements.
  logic [5:0] m_hi, mb_hi;
  logic [7:0] m_lo, mb_lo;
  logic [13:0] m_dac, mb_dac;
  logic m_err, m_wrq, m_ldq;
  int m_rem;

  task automatic model_step();
    logic [5:0] nh, bnh;
    logic [7:0] nl, bnl;
    logic rise, viol;
    if (rst) begin
      m_hi = 0; m_lo = 0; m_dac = 0; mb_hi = 0; mb_lo = 0; mb_dac = 0;
      m_err = 0; m_wrq = 1; m_ldq = 1; m_rem = 0;
      return;
    end
    nh  = (!wr_n && !sh_n)  ? din[13:8]  : m_hi;
    nl  = (!wr_n && !sl_n)  ? din[7:0]   : m_lo;
    bnh = (!wr_n && !bsh_n) ? bdin[13:8] : mb_hi;
    bnl = (!wr_n && !bsl_n) ? bdin[7:0]  : mb_lo;
    if (!wr_n && !ld_n) begin m_dac = {nh, nl}; mb_dac = {bnh, bnl}; end
    m_hi = nh; m_lo = nl; mb_hi = bnh; mb_lo = bnl;
    rise = wr_n && !m_wrq && !m_ldq;
    viol = ld_n && (rise || m_rem != 0);
    if (rise && !ld_n) m_rem = LDM - 1;
    else if (m_rem != 0) m_rem = ld_n ? 0 : m_rem - 1;
    if (viol) m_err = 1; else if (clr) m_err = 0;
    m_wrq = wr_n; m_ldq = ld_n;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: inputs were set at a falling edge, sample at the next one.
  task automatic cyc(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk({tag, " dac"}, 16'(dac_a), 16'(m_dac));
    chk({tag, " err"}, 16'(err_a), 16'(m_err));
  endtask

  task automatic drv(input logic h, input logic l, input logic w, input logic d,
                     input logic [13:0] v);
    sh_n = h; sl_n = l; wr_n = w; ld_n = d; din = v;
  endtask

  task automatic idle();
    drv(1, 1, 1, 1, din);
    bsh_n = 1; bsl_n = 1;
  endtask

  // Transfer with a correct load hold afterwards.
  task automatic xfer_ok(input string tag);
    drv(1, 1, 0, 0, din); cyc(tag);
    wr_n = 1; for (int k = 0; k < LDM; k++) cyc(tag);
    idle(); cyc(tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    @(negedge clk);
    cyc("R11 reset"); cyc("R11 reset");
    rst = 0; idle();
    cyc("R11 after reset");

    // R1: upper only, output unchanged until transfer
    drv(0, 1, 0, 1, 14'h3A55); cyc("R1 upper load");
    idle(); cyc("R1 idle");
    xfer_ok("R4 transfer upper");
    chk("R4 value", 16'(dac_a), 16'h3A00);

    // R2
    drv(1, 0, 0, 1, 14'h0C7E); cyc("R2 lower load");
    idle(); xfer_ok("R4 transfer lower");
    chk("R2 value", 16'(dac_a), 16'h3A7E);

    // R3
    drv(0, 0, 0, 1, 14'h1234); cyc("R3 both load");
    chk("R3 dac held", 16'(dac_a), 16'h3A7E);
    idle(); xfer_ok("R4 transfer both");
    chk("R3 value", 16'(dac_a), 16'h1234);

    // R5 transparent: full scale, then zero
    drv(0, 0, 0, 0, 14'h3FFF); cyc("R5 transparent");
    chk("R5 full scale", 16'(dac_a), 16'h3FFF);
    drv(0, 0, 0, 0, 14'h0000); cyc("R5 transparent zero");
    chk("R5 zero", 16'(dac_a), 16'h0000);
    wr_n = 1; for (int k = 0; k < LDM; k++) cyc("R5 hold");
    idle(); cyc("R5 idle");

    // R6: write high ignores everything; selects+load high ignored
    drv(0, 0, 1, 0, 14'h2AAA); cyc("R6 write high");
    chk("R6 write high err", 16'(err_a), 16'h0);
    idle(); drv(1, 1, 0, 1, 14'h1555); cyc("R6 noop write");
    idle(); xfer_ok("R6 transfer after noop");
    chk("R6 regs kept", 16'(dac_a), 16'h0000);

    // R7: merged byte plus transfer in one edge
    drv(0, 0, 0, 1, 14'h0F0F); cyc("R7 stage");
    drv(0, 1, 0, 0, 14'h2800); cyc("R7 upper+xfer");
    chk("R7 merged upper", 16'(dac_a), 16'h280F);
    wr_n = 1; for (int k = 0; k < LDM; k++) cyc("R7 hold");
    drv(1, 0, 0, 0, 14'h00C3); cyc("R7 lower+xfer");
    chk("R7 merged lower", 16'(dac_a), 16'h28C3);
    wr_n = 1; for (int k = 0; k < LDM; k++) cyc("R7 hold");
    idle(); cyc("R7 idle");
    chk("R7 no error", 16'(err_a), 16'h0);

    // R8: released with write
    drv(1, 1, 0, 0, din); cyc("R8 xfer");
    idle(); cyc("R8 early release");
    chk("R8 early flag", 16'(err_a), 16'h1);
    cyc("R9 sticky");
    chk("R9 sticky", 16'(err_a), 16'h1);
    clr = 1; cyc("R9 clear"); clr = 0;
    chk("R9 cleared", 16'(err_a), 16'h0);
    // R8: released late inside window
    drv(1, 1, 0, 0, din); cyc("R8 xfer");
    wr_n = 1; cyc("R8 hold 1");
    ld_n = 1; cyc("R8 late release");
    chk("R8 late flag", 16'(err_a), 16'h1);
    clr = 1; cyc("R9 clear"); clr = 0;
    // R9: violation and clear in one cycle
    drv(1, 1, 0, 0, din); cyc("R9 xfer");
    idle(); clr = 1; cyc("R9 set beats clear"); clr = 0;
    chk("R9 set wins", 16'(err_a), 16'h1);
    clr = 1; cyc("R9 clear"); clr = 0;

    // R10: shared strobes, two instances
    drv(0, 0, 0, 1, 14'h0111); bsh_n = 0; bsl_n = 0; bdin = 14'h3222;
    cyc("R10 stage");
    idle(); drv(1, 1, 0, 0, din); cyc("R10 shared xfer");
    chk("R10 inst a", 16'(dac_a), 16'h0111);
    chk("R10 inst b same edge", 16'(dac_b), 16'h3222);
    wr_n = 1; for (int k = 0; k < LDM; k++) cyc("R10 hold");
    idle(); cyc("R10 idle");

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      sh_n = r[0]; sl_n = r[1]; wr_n = r[2]; ld_n = r[3] & r[4];
      bsh_n = r[5]; bsl_n = r[6];
      clr = ($urandom % 16) == 0;
      din = 14'($urandom); bdin = 14'($urandom);
      rst = (i == 2500);
      cyc(rst ? "R11 random reset" : "random");
      chk("R10 random inst b", 16'(dac_b), 16'(mb_dac));
    end
    rst = 0; clr = 0;
    idle(); cyc("final");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule